// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This block keeps the machine-level trap state of a small RISC-V core that runs only in machine mode: the handler vector, the saved exception PC, the cause, the trap value and the two interrupt-enable bits of the status register. When the pipeline raises a trap request, the unit saves the trapping PC, the cause and a trap value. It also saves the old interrupt enable and then clears it. One cycle later it presents the handler address on a redirect output. When the pipeline raises a return request, the unit restores the interrupt enable and presents the saved PC as the resume address. The resume PC is masked to the instruction alignment that the configured ISA word allows.

A small controller with three states sequences the work. **ST_RUN** accepts requests and CSR writes. **ST_ENTER** drives the handler address for one cycle. **ST_RETURN** drives the resume address for one cycle. The transitions are **RUN→ENTER** (trap accepted), **RUN→RETURN** (return accepted with no trap), **RUN→RUN** (no request), **ENTER→RUN** and **RETURN→RUN** (always, after one cycle). A CSR port with a combinational read and a synchronous write gives the core's CSR instructions access to the registers.

Top module: `mtrap_unit`

## Requirements
- R1: After reset, redirect_vld is 0. The status register (0x300) reads 0 and the vector register (0x305) reads MTVEC_RST. The ISA word (0x301) reads MISA_VAL. The vendor (0xF11), architecture (0xF12) and implementation (0xF13) IDs read 0x669, 0x80000003 and 1.
- R2: Writes to 0x301, 0xF11, 0xF12 and 0xF13 are ignored, and reads return the reset value.
- R3: A read of 0x305 returns the stored value with bit 1 forced to 0. Bit 0 selects vectored mode.
- R4: An accepted trap request raises redirect_vld for exactly the next cycle. In the same edge, the saved PC (0x341) takes trap_pc and the cause (0x342) takes {trap_irq in bit XLEN-1, trap_cause zero-extended}. The previous-enable bit (status bit 7) takes the old enable (status bit 3), and the enable bit is cleared.
- R5: The handler address is the vector register with bits 1:0 cleared. When bit 0 is set and the trap is an interrupt, 4 × cause is added. Exceptions always go to the base.
- R6: For an illegal-instruction exception (cause 2), the trap value (0x343) takes trap_info whole if trap_info[1:0] is 2'b11. Otherwise it takes trap_info[15:0] zero-extended.
- R7: For exception causes 0, 1, 4, 5, 6 and 7 (address faults and misalignments), the trap value takes trap_info. Every other exception and every interrupt sets it to 0.
- R8: An accepted return request copies status bit 7 into bit 3 and sets bit 7. In the next cycle, redirect_pc is the saved PC ANDed with ~1 when MISA_VAL bit 2 is set, or with ~3 when it is clear.
- R9: irq_take is 1 exactly when status bit 3 is set and irq_pend AND the enable register (0x304, low IRQ_W bits) is non-zero.
- R10: A trap request wins over a return request in the same cycle. Requests that arrive while redirect_vld is high are ignored. A CSR write in the same cycle as an accepted request is dropped.
- R11: Status reads return only bit 3 and bit 7, with the other bits 0. Registers 0x341, 0x342 and 0x343 store writes in full and read them back unchanged. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request from the pipeline |
| trap_irq | input | 1 | Trap is an interrupt (1) or an exception (0) |
| trap_cause | input | CAUSE_W | Cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_info | input | XLEN | Faulting instruction word or faulting address |
| mret_req | input | 1 | Return-from-trap request |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_take | output | 1 | An enabled interrupt is pending and globally enabled |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| redirect_vld | output | 1 | Redirect the fetch to redirect_pc |
| redirect_pc | output | XLEN | Handler or resume address |

## Verification
The hardest case to reach from the ports is a second request that arrives during the single redirect cycle. To get there, the stimulus holds trap_req high for two edges with a different PC and cause on the second edge. It then checks that the saved PC and cause keep the first trap's values and that no second redirect appears. The bench also collides a trap with a return request and with a vector-register write in the same cycle. This shows that the trap wins and that the handler address comes from the old vector. A second instance built without the compressed bit checks the coarser resume mask.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ENTER  = 2'd1,
        ST_RETURN = 2'd2
    } mt_state_e;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ISA     = 12'h301;
    localparam logic [11:0] A_IEN     = 12'h304;
    localparam logic [11:0] A_VECTOR  = 12'h305;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;
    localparam logic [11:0] A_VENDOR  = 12'hF11;
    localparam logic [11:0] A_ARCH    = 12'hF12;
    localparam logic [11:0] A_IMPL    = 12'hF13;

    localparam int BIT_IE   = 3;
    localparam int BIT_PIE  = 7;

    localparam int unsigned CODE_ILLEGAL = 2;

    function automatic logic carries_addr(input int unsigned code);
        return (code == 0) || (code == 1) || (code == 4) ||
               (code == 5) || (code == 6) || (code == 7);
    endfunction

endpackage

// File: rtl/mtrap_fsm.sv
module mtrap_fsm
    import mtrap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trap_req,
    input  logic      mret_req,
    output logic      take_trap,
    output logic      take_ret,
    output mt_state_e state
);

    mt_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        take_trap = (state == ST_RUN) && trap_req;
        take_ret  = (state == ST_RUN) && mret_req && !trap_req;
        state_nx  = ST_RUN;
        unique case (state)
            ST_RUN: begin
                if (take_trap)     state_nx = ST_ENTER;
                else if (take_ret) state_nx = ST_RETURN;
                else               state_nx = ST_RUN;
            end
            ST_ENTER:  state_nx = ST_RUN;
            ST_RETURN: state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    assert_enter_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> state == ST_ENTER);

    assert_return_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_ret |=> state == ST_RETURN);

    assert_one_cycle_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_RUN |=> state == ST_RUN);

endmodule

// File: rtl/mtrap_tval.sv
module mtrap_tval
    import mtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               irq,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    info,
    output logic [XLEN-1:0]    tval
);

    always_comb begin
        tval = '0;
        if (!irq) begin
            if (32'(cause) == CODE_ILLEGAL) begin
                if (info[1:0] == 2'b11) tval = info;
                else                    tval = {{(XLEN-16){1'b0}}, info[15:0]};
            end else if (carries_addr(32'(cause))) begin
                tval = info;
            end
        end
    end

endmodule

// File: rtl/mtrap_target.sv
module mtrap_target
    import mtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5,
    parameter bit C_EXT   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mt_state_e          state,
    input  logic [XLEN-1:0]    vector,
    input  logic               cause_irq,
    input  logic [CAUSE_W-1:0] cause_code,
    input  logic [XLEN-1:0]    epc,
    output logic               redirect_vld,
    output logic [XLEN-1:0]    redirect_pc
);

    localparam logic [XLEN-1:0] RET_MASK = C_EXT ? ~XLEN'(1) : ~XLEN'(3);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] slot;

    always_comb begin
        base = {vector[XLEN-1:2], 2'b00};
        slot = XLEN'(cause_code) << 2;
        redirect_vld = 1'b0;
        redirect_pc  = '0;
        unique case (state)
            ST_ENTER: begin
                redirect_vld = 1'b1;
                redirect_pc  = (vector[0] && cause_irq) ? base + slot : base;
            end
            ST_RETURN: begin
                redirect_vld = 1'b1;
                redirect_pc  = epc & RET_MASK;
            end
            default: begin
                redirect_vld = 1'b0;
                redirect_pc  = '0;
            end
        endcase
    end

    assert_handler_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER) |-> redirect_pc[1:0] == 2'b00);

    assert_resume_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETURN) |-> (!redirect_pc[0] && (C_EXT || !redirect_pc[1])));

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CAUSE_W   = 5,
    parameter int              IRQ_W     = 16,
    parameter logic [XLEN-1:0] MISA_VAL  = 32'h4000_0104,
    parameter logic [XLEN-1:0] VENDOR_ID = 32'h0000_0669,
    parameter logic [XLEN-1:0] ARCH_ID   = 32'h8000_0003,
    parameter logic [XLEN-1:0] IMPL_ID   = 32'h0000_0001,
    parameter logic [XLEN-1:0] MTVEC_RST = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic               trap_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [XLEN-1:0]    trap_info,
    input  logic               mret_req,
    input  logic [IRQ_W-1:0]   irq_pend,
    output logic               irq_take,
    input  logic               csr_we,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               redirect_vld,
    output logic [XLEN-1:0]    redirect_pc
);

    localparam bit C_EXT   = MISA_VAL[2];
    localparam int PAD_W   = XLEN - 1 - CAUSE_W;

    mt_state_e        state;
    logic             take_trap;
    logic             take_ret;
    logic             st_ie;
    logic             st_pie;
    logic [IRQ_W-1:0] ien_q;
    logic [XLEN-1:0]  vector_q;
    logic [XLEN-1:0]  epc_q;
    logic [XLEN-1:0]  cause_q;
    logic [XLEN-1:0]  tval_q;
    logic [XLEN-1:0]  tval_new;

    mtrap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_req  (trap_req),
        .mret_req  (mret_req),
        .take_trap (take_trap),
        .take_ret  (take_ret),
        .state     (state)
    );

    mtrap_tval #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_tval (
        .irq   (trap_irq),
        .cause (trap_cause),
        .info  (trap_info),
        .tval  (tval_new)
    );

    mtrap_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .C_EXT(C_EXT)) u_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .vector       (vector_q),
        .cause_irq    (cause_q[XLEN-1]),
        .cause_code   (cause_q[CAUSE_W-1:0]),
        .epc          (epc_q),
        .redirect_vld (redirect_vld),
        .redirect_pc  (redirect_pc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_ie    <= 1'b0;
            st_pie   <= 1'b0;
            ien_q    <= '0;
            vector_q <= MTVEC_RST;
            epc_q    <= '0;
            cause_q  <= '0;
            tval_q   <= '0;
        end else if (take_trap) begin
            epc_q   <= trap_pc;
            cause_q <= {trap_irq, {PAD_W{1'b0}}, trap_cause};
            tval_q  <= tval_new;
            st_pie  <= st_ie;
            st_ie   <= 1'b0;
        end else if (take_ret) begin
            st_ie  <= st_pie;
            st_pie <= 1'b1;
        end else if (csr_we) begin
            case (csr_addr)
                A_STATUS: begin
                    st_ie  <= csr_wdata[BIT_IE];
                    st_pie <= csr_wdata[BIT_PIE];
                end
                A_IEN:    ien_q    <= csr_wdata[IRQ_W-1:0];
                A_VECTOR: vector_q <= csr_wdata;
                A_EPC:    epc_q    <= csr_wdata;
                A_CAUSE:  cause_q  <= csr_wdata;
                A_TVAL:   tval_q   <= csr_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            A_STATUS: begin
                csr_rdata[BIT_IE]  = st_ie;
                csr_rdata[BIT_PIE] = st_pie;
            end
            A_ISA:    csr_rdata = MISA_VAL;
            A_IEN:    csr_rdata = XLEN'(ien_q);
            A_VECTOR: csr_rdata = vector_q & ~XLEN'(2);
            A_EPC:    csr_rdata = epc_q;
            A_CAUSE:  csr_rdata = cause_q;
            A_TVAL:   csr_rdata = tval_q;
            A_VENDOR: csr_rdata = VENDOR_ID;
            A_ARCH:   csr_rdata = ARCH_ID;
            A_IMPL:   csr_rdata = IMPL_ID;
            default:  csr_rdata = '0;
        endcase
    end

    assign irq_take = st_ie && (|(irq_pend & ien_q));

    assert_entry_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (!st_ie && st_pie == $past(st_ie)));

    assert_entry_epc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> epc_q == $past(trap_pc));

    assert_return_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_ret |=> (st_pie && st_ie == $past(st_pie)));

    assert_short_insn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && !trap_irq && 32'(trap_cause) == CODE_ILLEGAL && trap_info[1:0] != 2'b11)
        |=> tval_q[XLEN-1:16] == '0);

    assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && !csr_we) |=> ($stable(epc_q) && $stable(cause_q) && $stable(st_ie)));

endmodule

// File: tb/mtrap_unit_bench.sv
module mtrap_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 5;
    localparam int IRQ_W   = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trap_req = 1'b0;
    logic               trap_irq = 1'b0;
    logic [CAUSE_W-1:0] trap_cause = '0;
    logic [XLEN-1:0]    trap_pc = '0;
    logic [XLEN-1:0]    trap_info = '0;
    logic               mret_req = 1'b0;
    logic [IRQ_W-1:0]   irq_pend = '0;
    logic               irq_take;
    logic               csr_we = 1'b0;
    logic [11:0]        csr_addr = '0;
    logic [XLEN-1:0]    csr_wdata = '0;
    logic [XLEN-1:0]    csr_rdata;
    logic               redirect_vld;
    logic [XLEN-1:0]    redirect_pc;

    logic               n_we = 1'b0;
    logic [11:0]        n_addr = '0;
    logic [XLEN-1:0]    n_wdata = '0;
    logic               n_mret = 1'b0;
    logic               n_take;
    logic [XLEN-1:0]    n_rdata;
    logic               n_vld;
    logic [XLEN-1:0]    n_pc;

    logic rd_chk = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;

    logic [XLEN-1:0] rd_exp[$];
    string           rd_tag[$];
    logic [XLEN-1:0] rx_exp[$];
    string           rx_tag[$];
    logic [XLEN-1:0] nx_exp[$];
    string           nx_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mtrap_unit u_mtrap_unit (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_info(trap_info),
        .mret_req(mret_req), .irq_pend(irq_pend), .irq_take(irq_take),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc)
    );

    mtrap_unit #(.MISA_VAL(32'h4000_0100)) u_mtrap_unit_noc (
        .clk(clk), .rst_n(rst_n), .trap_req(1'b0), .trap_irq(1'b0),
        .trap_cause('0), .trap_pc('0), .trap_info('0),
        .mret_req(n_mret), .irq_pend('0), .irq_take(n_take),
        .csr_we(n_we), .csr_addr(n_addr), .csr_wdata(n_wdata),
        .csr_rdata(n_rdata), .redirect_vld(n_vld), .redirect_pc(n_pc)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as results appear
    logic [XLEN-1:0] m_e;
    string           m_t;
    always @(negedge clk) begin
        if (rd_chk) begin
            if (rd_exp.size() == 0) check("R11 read with empty scoreboard", csr_rdata, 'x);
            else begin
                m_e = rd_exp.pop_front();
                m_t = rd_tag.pop_front();
                check(m_t, csr_rdata, m_e);
            end
        end
        if (rst_n && redirect_vld) begin
            if (rx_exp.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10 unexpected redirect: actual %h expected none", redirect_pc);
            end else begin
                m_e = rx_exp.pop_front();
                m_t = rx_tag.pop_front();
                check(m_t, redirect_pc, m_e);
            end
        end
        if (rst_n && n_vld) begin
            if (nx_exp.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R8 unexpected redirect: actual %h expected none", n_pc);
            end else begin
                m_e = nx_exp.pop_front();
                m_t = nx_tag.pop_front();
                check(m_t, n_pc, m_e);
            end
        end
    end

    task automatic csr_wr(input logic [11:0] a, input logic [XLEN-1:0] d);
        @(posedge clk); #1;
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(posedge clk); #1;
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [11:0] a, input logic [XLEN-1:0] exp, input string tag);
        @(posedge clk); #1;
        csr_addr = a; rd_chk = 1'b1;
        rd_exp.push_back(exp); rd_tag.push_back(tag);
        @(negedge clk); #1;
        rd_chk = 1'b0;
    endtask

    task automatic do_trap(input logic irq, input logic [CAUSE_W-1:0] c,
                           input logic [XLEN-1:0] pc, input logic [XLEN-1:0] info,
                           input logic [XLEN-1:0] exp_pc, input string tag);
        @(posedge clk); #1;
        trap_req = 1'b1; trap_irq = irq; trap_cause = c; trap_pc = pc; trap_info = info;
        rx_exp.push_back(exp_pc); rx_tag.push_back(tag);
        @(posedge clk); #1;
        trap_req = 1'b0;
        @(posedge clk);
    endtask

    task automatic do_mret(input logic [XLEN-1:0] exp_pc, input string tag);
        @(posedge clk); #1;
        mret_req = 1'b1;
        rx_exp.push_back(exp_pc); rx_tag.push_back(tag);
        @(posedge clk); #1;
        mret_req = 1'b0;
        @(posedge clk);
    endtask

    task automatic irq_chk(input logic [IRQ_W-1:0] p, input logic exp, input string tag);
        @(posedge clk); #1;
        irq_pend = p;
        @(negedge clk);
        check(tag, XLEN'(irq_take), XLEN'(exp));
    endtask

    task automatic finish_run();
        if (rd_exp.size() != 0 || rx_exp.size() != 0 || nx_exp.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R4 scoreboard not drained: actual %0d expected 0",
                     rd_exp.size() + rx_exp.size() + nx_exp.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 redirect_vld after reset", XLEN'(redirect_vld), '0);

        // R1 reset values
        csr_rd(12'h300, 32'h0, "R1 status reset");
        csr_rd(12'h305, 32'h0, "R1 vector reset");
        csr_rd(12'h301, 32'h4000_0104, "R1 isa word");
        csr_rd(12'hF11, 32'h669, "R1 vendor id");
        csr_rd(12'hF12, 32'h8000_0003, "R1 arch id");
        csr_rd(12'hF13, 32'h1, "R1 impl id");

        // R2 read-only identity
        csr_wr(12'h301, 32'hFFFF_FFFF);
        csr_wr(12'hF11, 32'h0);
        csr_wr(12'hF13, 32'h1234);
        csr_rd(12'h301, 32'h4000_0104, "R2 isa write ignored");
        csr_rd(12'hF11, 32'h669, "R2 vendor write ignored");
        csr_rd(12'hF13, 32'h1, "R2 impl write ignored");

        // R3 vector read view
        csr_wr(12'h305, 32'h0000_1003);
        csr_rd(12'h305, 32'h0000_1001, "R3 vector bit1 cleared");

        // R11 status field view, unmapped address
        csr_wr(12'h300, 32'h0000_0088);
        csr_rd(12'h300, 32'h88, "R11 status both bits");
        csr_wr(12'h300, 32'hFFFF_FFFF);
        csr_rd(12'h300, 32'h88, "R11 status other bits zero");
        csr_rd(12'h7C0, 32'h0, "R11 unmapped reads zero");

        // R9 interrupt gating
        csr_wr(12'h304, 32'h0000_0080);
        csr_wr(12'h300, 32'h0000_0008);
        irq_chk(16'h0080, 1'b1, "R9 pending and enabled");
        irq_chk(16'h0008, 1'b0, "R9 pending not enabled");
        csr_wr(12'h300, 32'h0000_0000);
        irq_chk(16'h0080, 1'b0, "R9 global enable clear");
        irq_pend = '0;

        // R4 R5 R7 vectored interrupt
        csr_wr(12'h305, 32'h0000_1001);
        csr_wr(12'h300, 32'h0000_0008);
        do_trap(1'b1, 5'd7, 32'h200, 32'hABCD, 32'h0000_101C, "R5 vectored interrupt handler");
        csr_rd(12'h300, 32'h80, "R4 enable saved and cleared");
        csr_rd(12'h341, 32'h200, "R4 saved pc");
        csr_rd(12'h342, 32'h8000_0007, "R4 cause with interrupt bit");
        csr_rd(12'h343, 32'h0, "R7 interrupt trap value zero");

        // R5 exception in vectored mode goes to base
        do_trap(1'b0, 5'd11, 32'h240, 32'h55, 32'h0000_1000, "R5 exception to base");
        csr_rd(12'h342, 32'h0000_000B, "R4 exception cause");
        csr_rd(12'h300, 32'h0, "R4 previous enable from cleared");
        csr_rd(12'h343, 32'h0, "R7 other exception value zero");

        // R6 illegal instruction value
        do_trap(1'b0, 5'd2, 32'h280, 32'hDEAD_0013, 32'h0000_1000, "R5 illegal to base");
        csr_rd(12'h343, 32'hDEAD_0013, "R6 full width instruction");
        do_trap(1'b0, 5'd2, 32'h284, 32'h1234_4001, 32'h0000_1000, "R5 illegal short to base");
        csr_rd(12'h343, 32'h0000_4001, "R6 short instruction low half");

        // R7 address faults
        do_trap(1'b0, 5'd5, 32'h288, 32'h8000_1234, 32'h0000_1000, "R5 load fault to base");
        csr_rd(12'h343, 32'h8000_1234, "R7 load fault address");
        do_trap(1'b0, 5'd6, 32'h28C, 32'h0000_0FF2, 32'h0000_1000, "R5 store misalign to base");
        csr_rd(12'h343, 32'h0000_0FF2, "R7 store misalign address");
        do_trap(1'b0, 5'd3, 32'h290, 32'h0000_0055, 32'h0000_1000, "R5 breakpoint to base");
        csr_rd(12'h343, 32'h0, "R7 non-fault cause clears value");

        // R8 return with compressed mask
        csr_wr(12'h341, 32'h0000_0403);
        csr_rd(12'h341, 32'h0000_0403, "R11 saved pc raw readback");
        csr_wr(12'h300, 32'h0000_0080);
        do_mret(32'h0000_0402, "R8 resume masked by ~1");
        csr_rd(12'h300, 32'h88, "R8 enable restored from previous");
        csr_wr(12'h300, 32'h0000_0008);
        do_mret(32'h0000_0402, "R8 resume second");
        csr_rd(12'h300, 32'h80, "R8 previous set enable cleared");

        // R8 instance without compressed bit
        @(posedge clk); #1;
        n_we = 1'b1; n_addr = 12'h341; n_wdata = 32'h0000_0407;
        @(posedge clk); #1;
        n_we = 1'b0; n_mret = 1'b1;
        nx_exp.push_back(32'h0000_0404); nx_tag.push_back("R8 resume masked by ~3");
        @(posedge clk); #1;
        n_mret = 1'b0;
        @(posedge clk);

        // R10 trap wins over return
        csr_wr(12'h305, 32'h0000_1000);
        csr_wr(12'h300, 32'h0000_0008);
        @(posedge clk); #1;
        trap_req = 1'b1; mret_req = 1'b1; trap_irq = 1'b0; trap_cause = 5'd11;
        trap_pc = 32'h300; trap_info = '0;
        rx_exp.push_back(32'h0000_1000); rx_tag.push_back("R10 trap beats return");
        @(posedge clk); #1;
        trap_req = 1'b0; mret_req = 1'b0;
        @(posedge clk);
        csr_rd(12'h300, 32'h80, "R10 status shows trap taken");
        csr_rd(12'h341, 32'h300, "R10 saved pc from trap");

        // R10 request during redirect ignored
        @(posedge clk); #1;
        trap_req = 1'b1; trap_cause = 5'd11; trap_pc = 32'h500;
        rx_exp.push_back(32'h0000_1000); rx_tag.push_back("R10 first of held request");
        @(posedge clk); #1;
        trap_cause = 5'd3; trap_pc = 32'h600;
        @(posedge clk); #1;
        trap_req = 1'b0;
        @(posedge clk);
        csr_rd(12'h341, 32'h500, "R10 busy request left saved pc");
        csr_rd(12'h342, 32'h0000_000B, "R10 busy request left cause");

        // R10 CSR write dropped under accepted trap
        @(posedge clk); #1;
        trap_req = 1'b1; trap_cause = 5'd11; trap_pc = 32'h700;
        csr_we = 1'b1; csr_addr = 12'h305; csr_wdata = 32'h0000_5000;
        rx_exp.push_back(32'h0000_1000); rx_tag.push_back("R10 handler from old vector");
        @(posedge clk); #1;
        trap_req = 1'b0; csr_we = 1'b0;
        @(posedge clk);
        csr_rd(12'h305, 32'h0000_1000, "R10 colliding write dropped");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule